// File: doc/BRIEF.md
# Two-Wire Slave Front End for a 12-Bit DAC

This block is the serial-bus slave that sits in front of a 12-bit voltage-output DAC. It samples the two bus lines (clock and data) with the system clock, finds start and stop conditions, and matches its own 7-bit address. It acknowledges by pulling the data line low through an output enable. It never drives the line high.

A write delivers 16-bit words as pairs of bytes. Each complete pair updates the DAC code and the power-down mode in the same cycle, with a one-cycle strobe. Any number of pairs may follow a single address. A read returns the last committed word, high byte first, for as long as the master keeps acknowledging.

Top module: `i2c_dac_slave`

## Requirements
- R1: After reset, `dac_code` is 0, `pd_mode` is 00, `dac_update` is 0 and `sda_oe` is 0.
- R2: The device address is the five bits 00011 followed by `addr_sel[1]` and `addr_sel[0]`. A matching address byte is acknowledged by `sda_oe` being high during the ninth clock pulse, for both writes (R/W bit 0) and reads (R/W bit 1).
- R3: A non-matching address is not acknowledged. All bytes up to the next start are ignored, and `dac_code` and `pd_mode` are unchanged.
- R4: Within a word, first-byte bits 7:6 are ignored, first-byte bits 5:4 become `pd_mode`, and first-byte bits 3:0 become `dac_code[11:8]`. The second byte becomes `dac_code[7:0]`. Bits are received MSB first.
- R5: `dac_update` is high for exactly one cycle for each committed word. `dac_code` and `pd_mode` change only in that cycle.
- R6: Every complete byte pair in one addressed write commits its own word and raises its own update pulse.
- R7: A single trailing byte left when a stop or start arrives is discarded. It produces no update, and the next byte after a new address starts a fresh pair.
- R8: A read returns {00, pd_mode, dac_code}, high byte first and then low byte. The same pair repeats while the master acknowledges.
- R9: After the master answers a read byte with no-acknowledge, `sda_oe` is low until the next start. `sda_oe` only rises while the synchronized clock line is low.
- R10: A start received in the middle of a byte aborts that transfer and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 2 | Strap pins giving the two low address bits |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| dac_code | output | 12 | Committed DAC code |
| pd_mode | output | 2 | Committed power-down mode, 00 means normal operation |
| dac_update | output | 1 | One-cycle strobe when a new word is committed |

## Verification
The bench writes odd byte counts and then stops. A design that committed half a word would change the code there, or would pair a stale byte with the first byte of the next transaction. It sends several pairs under one address, so a design that updated only once per transaction loses later words. It reads past the second byte, which catches a design that does not wrap back to the high byte. It also checks that the data line is released after a no-acknowledge, because a design that kept driving would block the master's stop. Restarts in the middle of a byte and foreign addresses must leave the outputs unchanged.

// File: rtl/i2cdac_pkg.sv
package i2cdac_pkg;
    localparam int CODE_W   = 12;
    localparam int MODE_W   = 2;
    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int SEL_W    = 2;
    localparam int FIXED_W  = 7 - SEL_W;
    localparam logic [FIXED_W-1:0] ADDR_FIXED = 5'b00011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } pstate_t;

    typedef struct packed {
        logic [1:0]        spare;
        logic [MODE_W-1:0] mode;
        logic [CODE_W-1:0] code;
    } dac_word_t;

    function automatic dac_word_t make_word(input logic [BYTE_W-1:0] hi,
                                            input logic [BYTE_W-1:0] lo);
        dac_word_t w;
        w.spare = 2'b00;
        w.mode  = hi[5:4];
        w.code  = {hi[3:0], lo};
        return w;
    endfunction
endpackage

// File: rtl/i2cdac_sync.sv
module i2cdac_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_prev, sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s && !scl_prev;
    assign scl_fall  = !scl_s && scl_prev;
    assign start_det = scl_s && scl_prev && sda_prev && !sda_s;
    assign stop_det  = scl_s && scl_prev && !sda_prev && sda_s;
endmodule

// File: rtl/i2cdac_proto.sv
module i2cdac_proto
    import i2cdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic [WORD_W-1:0] rd_word,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              sda_oe,
    output pstate_t           state
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              byte_full;
    logic              rw_bit;
    logic              send_lo;
    logic              got_nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '1;
            byte_full  <= 1'b0;
            rw_bit     <= 1'b0;
            send_lo    <= 1'b0;
            got_nack   <= 1'b0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (start_det) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                byte_full <= 1'b0;
            end else if (stop_det) begin
                state     <= ST_IDLE;
                byte_full <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == CNT_W'(BYTE_W - 1))
                                byte_full <= 1'b1;
                        end else if (scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            bit_cnt   <= '0;
                            if (state == ST_ADDR) begin
                                if (rx_sh[BYTE_W-1:1] == {ADDR_FIXED, addr_sel}) begin
                                    state  <= ST_AACK;
                                    rw_bit <= rx_sh[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                state      <= ST_WACK;
                                byte_valid <= 1'b1;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            if (rw_bit) begin
                                state   <= ST_RDATA;
                                tx_sh   <= rd_word[WORD_W-1:BYTE_W];
                                send_lo <= 1'b1;
                                bit_cnt <= '0;
                            end else begin
                                state <= ST_WDATA;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall)
                            state <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                                state <= ST_RACK;
                            end else begin
                                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b1};
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise)
                            got_nack <= sda_s;
                        else if (scl_fall) begin
                            if (got_nack) begin
                                state <= ST_IDLE;
                            end else begin
                                state   <= ST_RDATA;
                                tx_sh   <= send_lo ? rd_word[BYTE_W-1:0]
                                                   : rd_word[WORD_W-1:BYTE_W];
                                send_lo <= !send_lo;
                                bit_cnt <= '0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign byte_data = rx_sh;
    assign sda_oe    = (state == ST_AACK) || (state == ST_WACK) ||
                       ((state == ST_RDATA) && !tx_sh[BYTE_W-1]);
endmodule

// File: rtl/i2cdac_wordreg.sv
module i2cdac_wordreg
    import i2cdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_clr,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic [WORD_W-1:0] rd_word,
    output logic [CODE_W-1:0] dac_code,
    output logic [MODE_W-1:0] pd_mode,
    output logic              dac_update
);
    logic [BYTE_W-1:0] hold_hi;
    logic              have_hi;
    dac_word_t         cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_hi    <= '0;
            have_hi    <= 1'b0;
            cur        <= '0;
            dac_update <= 1'b0;
        end else begin
            dac_update <= 1'b0;
            if (frame_clr) begin
                have_hi <= 1'b0;
            end else if (byte_valid) begin
                if (!have_hi) begin
                    hold_hi <= byte_data;
                    have_hi <= 1'b1;
                end else begin
                    cur        <= make_word(hold_hi, byte_data);
                    have_hi    <= 1'b0;
                    dac_update <= 1'b1;
                end
            end
        end
    end

    assign rd_word  = cur;
    assign dac_code = cur.code;
    assign pd_mode  = cur.mode;
endmodule

// File: rtl/i2c_dac_slave.sv
module i2c_dac_slave
    import i2cdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  addr_sel,
    output logic              sda_oe,
    output logic [CODE_W-1:0] dac_code,
    output logic [MODE_W-1:0] pd_mode,
    output logic              dac_update
);
    logic scl_sync, sda_sync, scl_rise, scl_fall, start_det, stop_det;
    logic              byte_valid;
    logic [BYTE_W-1:0] byte_data;
    logic [WORD_W-1:0] rd_word;
    pstate_t           proto_state;

    i2cdac_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_sync), .sda_s(sda_sync),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cdac_proto u_proto (
        .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_sync), .start_det(start_det), .stop_det(stop_det),
        .addr_sel(addr_sel), .rd_word(rd_word),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .sda_oe(sda_oe), .state(proto_state)
    );

    i2cdac_wordreg u_word (
        .clk(clk), .rst(rst), .frame_clr(start_det || stop_det),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .rd_word(rd_word), .dac_code(dac_code), .pd_mode(pd_mode),
        .dac_update(dac_update)
    );
endmodule

// File: rtl/i2cdac_checker.sv
module i2cdac_checker
    import i2cdac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              in_wack,
    input logic [CODE_W-1:0] dac_code,
    input logic [MODE_W-1:0] pd_mode,
    input logic              dac_update
);
    p_update_single_r5: assert property (@(posedge clk) disable iff (rst)
        dac_update |=> !dac_update);

    p_outputs_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !dac_update |-> $stable({dac_code, pd_mode}));

    p_update_after_byte_r6: assert property (@(posedge clk) disable iff (rst)
        dac_update |-> in_wack);

    p_oe_rise_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_dac_slave i2cdac_checker u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_s(scl_sync),
    .in_wack(proto_state == ST_WACK), .dac_code(dac_code),
    .pd_mode(pd_mode), .dac_update(dac_update)
);

// File: tb/i2c_dac_slave_tb.sv
module i2c_dac_slave_tb;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b00;
    logic sda_oe, dac_update;
    logic [11:0] dac_code;
    logic [1:0] pd_mode;
    wire bus_sda = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int upd_cnt = 0;
    int wide_cnt = 0;
    logic prev_upd = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    i2c_dac_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(bus_sda),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .dac_code(dac_code),
        .pd_mode(pd_mode), .dac_update(dac_update)
    );

    always @(posedge clk) begin
        prev_upd <= dac_update;
        if (dac_update) upd_cnt <= upd_cnt + 1;
        if (dac_update && prev_upd) wide_cnt <= wide_cnt + 1;
    end

    function automatic logic [15:0] exp_word(input logic [7:0] hi, input logic [7:0] lo);
        return {2'b00, hi[5:4], hi[3:0], lo};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait(); scl = 1'b1; qwait();
        sda_m = 1'b0; qwait(); scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait(); scl = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; qwait(); scl = 1'b1; qwait();
        acked = !bus_sda;
        qwait(); scl = 1'b0; qwait();
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait(); scl = 1'b1; qwait();
            b[i] = bus_sda;
            qwait(); scl = 1'b0; qwait();
        end
        send_bit(!give_ack);
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] sel, input logic rd);
        return {5'b00011, sel, rd};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        logic [15:0] model;
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        check("R1 code", dac_code, 0);
        check("R1 mode", pd_mode, 0);
        check("R1 update", dac_update, 0);
        check("R1 oe", sda_oe, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        model = 16'h0;

        // directed single write, address sel 01
        addr_sel = 2'b01;
        upd_cnt = 0;
        bus_start();
        write_byte(addr_byte(2'b01, 1'b0), ack);
        check("R2 write ack", ack, 1);
        write_byte(8'hE9, ack);
        write_byte(8'hA5, ack);
        bus_stop();
        model = exp_word(8'hE9, 8'hA5);
        repeat (4) @(negedge clk);
        check("R4 code", dac_code, model[11:0]);
        check("R4 mode", pd_mode, model[13:12]);
        check("R5 one update", upd_cnt, 1);

        // wrong address
        upd_cnt = 0;
        bus_start();
        write_byte(addr_byte(2'b10, 1'b0), ack);
        check("R3 no ack", ack, 0);
        write_byte(8'h12, ack);
        write_byte(8'h34, ack);
        bus_stop();
        repeat (4) @(negedge clk);
        check("R3 code kept", dac_code, model[11:0]);
        check("R3 no update", upd_cnt, 0);

        // start in the middle of a byte, then restart
        upd_cnt = 0;
        bus_start();
        write_byte(addr_byte(2'b01, 1'b0), ack);
        for (int i = 7; i >= 4; i--) send_bit(1'b0);
        bus_start();
        write_byte(addr_byte(2'b01, 1'b0), ack);
        check("R10 restart ack", ack, 1);
        write_byte(8'h07, ack);
        write_byte(8'hFF, ack);
        bus_stop();
        model = exp_word(8'h07, 8'hFF);
        repeat (4) @(negedge clk);
        check("R10 code", dac_code, model[11:0]);
        check("R10 updates", upd_cnt, 1);

        // read with wrap and nack
        bus_start();
        write_byte(addr_byte(2'b01, 1'b1), ack);
        check("R2 read ack", ack, 1);
        read_byte(1'b1, rb); check("R8 hi", rb, model[15:8]);
        read_byte(1'b1, rb); check("R8 lo", rb, model[7:0]);
        read_byte(1'b1, rb); check("R8 hi again", rb, model[15:8]);
        read_byte(1'b0, rb); check("R8 lo again", rb, model[7:0]);
        repeat (2) @(negedge clk);
        check("R9 released", sda_oe, 0);
        bus_stop();

        // random transactions
        for (int it = 0; it < 24; it++) begin
            logic [1:0] sel;
            logic foreign;
            int pairs;
            logic odd;
            sel = 2'($urandom_range(0, 3));
            addr_sel = sel;
            foreign = ($urandom_range(0, 5) == 0);
            pairs = $urandom_range(1, 3);
            odd = 1'($urandom_range(0, 1));
            upd_cnt = 0;
            bus_start();
            write_byte(addr_byte(foreign ? ~sel : sel, 1'b0), ack);
            check(foreign ? "R3 rnd ack" : "R2 rnd ack", ack, foreign ? 0 : 1);
            for (int p = 0; p < pairs; p++) begin
                logic [7:0] h, l;
                h = 8'($urandom); l = 8'($urandom);
                write_byte(h, ack);
                write_byte(l, ack);
                if (!foreign) model = exp_word(h, l);
            end
            if (odd) write_byte(8'($urandom), ack);
            bus_stop();
            repeat (4) @(negedge clk);
            check("R6 rnd updates", upd_cnt, foreign ? 0 : pairs);
            check("R7 rnd code", dac_code, model[11:0]);
            check("R4 rnd mode", pd_mode, model[13:12]);
            if (it % 4 == 0) begin
                bus_start();
                write_byte(addr_byte(sel, 1'b1), ack);
                read_byte(1'b1, rb); check("R8 rnd hi", rb, model[15:8]);
                read_byte(1'b0, rb); check("R8 rnd lo", rb, model[7:0]);
                repeat (2) @(negedge clk);
                check("R9 rnd release", sda_oe, 0);
                bus_stop();
            end
        end

        // odd byte then fresh pair in new transaction
        upd_cnt = 0;
        bus_start();
        write_byte(addr_byte(addr_sel, 1'b0), ack);
        write_byte(8'h3C, ack);
        bus_stop();
        bus_start();
        write_byte(addr_byte(addr_sel, 1'b0), ack);
        write_byte(8'h21, ack);
        write_byte(8'h43, ack);
        bus_stop();
        model = exp_word(8'h21, 8'h43);
        repeat (4) @(negedge clk);
        check("R7 fresh pair", dac_code, model[11:0]);
        check("R7 fresh mode", pd_mode, model[13:12]);
        check("R7 updates", upd_cnt, 1);
        check("R5 pulse width", wide_cnt, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule